// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers six interrupt requests, latches each one in a sticky request bit, gates them through per-source enables and a global master enable, and offers the CPU one request at a time. Three requests come from single-cycle time-out pulses from on-chip timers. The other three come from edge detectors on two external pins. Pin A raises one request on its falling edge and a different request on its rising edge. Pin B raises a request on its falling edge only.

Each pin passes through a synchronizer. An edge is then accepted only if the pin held its previous level for at least a programmable number of clocks, so short glitches do not raise requests. The CPU sees a level interrupt line and a combinational vector address. The address points at a two-byte slot chosen by fixed priority, with the lowest request number served first.

An acknowledge clears the chosen request and closes the master enable. A return strobe opens the master enable again, so nested service is off by default. Software reaches the enables, the pending bits and the glitch-filter length through a small register port.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the enable register (address 0) reads 0x00 and the pending register (address 1) reads 0x00. The filter length (address 2) reads its reset value of 2. `irq_o` is low and `vec_o` is 0.
- R2: A one-cycle pulse on `tmr_pulse_i[0]`, `[1]` or `[2]` sets pending bit 0, 2 or 5 respectively, visible from the next clock edge.
- R3: A falling edge on `ext_a_i` sets pending bit 1, and a rising edge on `ext_a_i` sets pending bit 4. A falling edge on `ext_b_i` sets pending bit 3, and a rising edge on `ext_b_i` sets no bit.
- R4: A pin change is seen through two synchronizer flops, so its pending bit appears at the third rising clock edge after the change. The edge is accepted only if the pin held its prior level for at least as many clocks as the filter length. A length of 0 accepts every edge.
- R5: `irq_o` is high exactly when the master enable (address 0, bit 7) is 1 and some pending bit has its enable bit (address 0, bits 0..5) set.
- R6: `vec_o` equals 2 + 2*i, where i is the lowest-numbered pending and enabled request. When no request is both pending and enabled, `vec_o` is 0. The master enable does not affect `vec_o`.
- R7: When `ack_i` is high while `irq_o` is high, the next edge clears the pending bit named by `vec_o` and clears the master enable, and all other pending bits keep their values. When `ack_i` is high while `irq_o` is low, nothing changes.
- R8: `mst_set_i` and `ret_i` set the master enable. `mst_clr_i` and an accepted acknowledge clear it, and a clear wins over a set in the same cycle. A register write to bit 7 of address 0 has the lowest precedence.
- R9: Writing address 1 clears each pending bit whose data bit is 0, and writing a 1 never sets a bit. If a source sets a bit in the same cycle that it is cleared, the bit stays set.
- R10: Address 0 bit 6 reads 0, and pending bits 7:6 at address 1 read 0. Address 3 holds the reserved request codes 8..15, which always read 0x00. Address 2 stores only its low 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_pulse_i | input | 3 | Timer time-out pulses (timers 0..2) |
| ext_a_i | input | 1 | Asynchronous pin, both edges used |
| ext_b_i | input | 1 | Asynchronous pin, falling edge used |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| mst_set_i | input | 1 | Master enable set strobe |
| mst_clr_i | input | 1 | Master enable clear strobe |
| ack_i | input | 1 | Interrupt acknowledge |
| ret_i | input | 1 | Interrupt return strobe |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 8 | Vector slot address |

## Verification
The assertions assume that the timer inputs are single-cycle pulses. They also assume the CPU raises the acknowledge only for the vector currently shown, and does not raise it in the same cycle as a set or return strobe. The bench drives every strobe for exactly one cycle, one strobe at a time. The only exceptions are the deliberate collision cases, and those are arranged so that no assertion antecedent fires. Pin changes are held for whole clock cycles, so the synchronized view of each pin has the same durations the bench computes.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int NUM_SRC  = 6;
   localparam int REG_W    = 8;
   localparam int NUM_PINS = 2;

   // source positions: the priority and the vector slot follow these indices
   localparam int SRC_T0     = 0;
   localparam int SRC_A_FALL = 1;
   localparam int SRC_T1     = 2;
   localparam int SRC_B_FALL = 3;
   localparam int SRC_A_RISE = 4;
   localparam int SRC_T2     = 5;

   // edge-enable code for a pin: bit 1 = rising, bit 0 = falling
   localparam logic [1:0] EDGE_BOTH = 2'b11;
   localparam logic [1:0] EDGE_FALL = 2'b01;

   typedef enum logic [1:0] {
      RS_ENABLE  = 2'd0,
      RS_PENDING = 2'd1,
      RS_FILTER  = 2'd2,
      RS_RESV    = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
   parameter int         SYNC_STAGES = 2,
   parameter int         HOLD_W      = 4,
   parameter logic       IDLE_LVL    = 1'b1,
   parameter logic [1:0] EDGES       = 2'b11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_i,
   input  logic [HOLD_W-1:0] hold_i,
   output logic              rise_o,
   output logic              fall_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("irq_pin_edge: SYNC_STAGES must be at least 2");
      end
      if (HOLD_W < 1) begin : g_bad_hold
         $error("irq_pin_edge: HOLD_W must be at least 1");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   lvl_q;
   logic [HOLD_W-1:0]      run_q;
   logic                   sampled;
   logic                   changed;
   logic                   held_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= {SYNC_STAGES{IDLE_LVL}};
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
   end

   assign sampled = sync_q[SYNC_STAGES-1];
   assign changed = sampled != lvl_q;
   assign held_ok = run_q >= hold_i;

   // run_q counts clocks the current level has been seen, saturating
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= IDLE_LVL;
         run_q <= '1;
      end else if (changed) begin
         lvl_q <= sampled;
         run_q <= HOLD_W'(1);
      end else if (run_q != '1) begin
         run_q <= run_q + HOLD_W'(1);
      end
   end

   generate
      if (EDGES[1]) begin : g_rise
         assign rise_o = changed & held_ok & sampled;
      end else begin : g_no_rise
         assign rise_o = 1'b0;
      end
      if (EDGES[0]) begin : g_fall
         assign fall_o = changed & held_ok & ~sampled;
      end else begin : g_no_fall
         assign fall_o = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
   parameter int N     = 6,
   parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [N-1:0]     onehot_o
);
   generate
      if (N < 1) begin : g_bad_n
         $error("irq_prio_sel: N must be positive");
      end
   endgenerate

   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IDX_W'(i);
      end
      any_o    = |req_i;
      onehot_o = any_o ? (N'(1) << idx_o) : '0;
   end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int         SYNC_STAGES = 2,
   parameter int         HOLD_W      = 4,
   parameter int         HOLD_RST    = 2,
   parameter int         VEC_W       = 8,
   parameter int         VEC_BASE    = 2,
   parameter int         VEC_STEP    = 2,
   parameter logic       PIN_IDLE    = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [2:0]               tmr_pulse_i,
   input  logic                     ext_a_i,
   input  logic                     ext_b_i,
   input  logic                     reg_we_i,
   input  logic [1:0]               reg_addr_i,
   input  logic [irq_pkg::REG_W-1:0] reg_wdata_i,
   output logic [irq_pkg::REG_W-1:0] reg_rdata_o,
   input  logic                     mst_set_i,
   input  logic                     mst_clr_i,
   input  logic                     ack_i,
   input  logic                     ret_i,
   output logic                     irq_o,
   output logic [VEC_W-1:0]         vec_o
);
   import irq_pkg::*;

   localparam int IDX_W   = $clog2(NUM_SRC);
   localparam int VEC_TOP = VEC_BASE + VEC_STEP * (NUM_SRC - 1);
   localparam logic [1:0] PIN_EDGES [NUM_PINS] = '{EDGE_BOTH, EDGE_FALL};

   generate
      if (HOLD_W < 1 || HOLD_W > REG_W) begin : g_bad_hold
         $error("prio_irq_ctrl: HOLD_W must lie in 1..REG_W");
      end
      if (HOLD_RST < 0 || HOLD_RST >= (1 << HOLD_W)) begin : g_bad_hold_rst
         $error("prio_irq_ctrl: HOLD_RST does not fit HOLD_W");
      end
      if (VEC_TOP >= (1 << VEC_W) || VEC_BASE < 1) begin : g_bad_vec
         $error("prio_irq_ctrl: vector slots do not fit VEC_W");
      end
   endgenerate

   logic [NUM_SRC-1:0]  mask_q;
   logic                mstr_q;
   logic                mstr_d;
   logic [NUM_SRC-1:0]  req_q;
   logic [NUM_SRC-1:0]  req_d;
   logic [HOLD_W-1:0]   hold_q;
   logic [NUM_SRC-1:0]  src_set;
   logic [NUM_SRC-1:0]  clr_ack;
   logic [NUM_SRC-1:0]  clr_sw;
   logic [NUM_SRC-1:0]  pend;
   logic [NUM_SRC-1:0]  sel_oh;
   logic [IDX_W-1:0]    sel_idx;
   logic                sel_any;
   logic                ack_go;
   logic                wr_enable;
   logic                wr_pending;
   logic                wr_filter;
   logic [NUM_PINS-1:0] pin_in;
   logic [NUM_PINS-1:0] pin_rise;
   logic [NUM_PINS-1:0] pin_fall;
   logic                unused_wbits;

   // ---------------- pin edge front ends ----------------
   assign pin_in = {ext_b_i, ext_a_i};

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         irq_pin_edge #(
            .SYNC_STAGES (SYNC_STAGES),
            .HOLD_W      (HOLD_W),
            .IDLE_LVL    (PIN_IDLE),
            .EDGES       (PIN_EDGES[p])
         ) u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_in[p]),
            .hold_i (hold_q),
            .rise_o (pin_rise[p]),
            .fall_o (pin_fall[p])
         );
      end
   endgenerate

   // ---------------- source map ----------------
   always_comb begin
      src_set             = '0;
      src_set[SRC_T0]     = tmr_pulse_i[0];
      src_set[SRC_T1]     = tmr_pulse_i[1];
      src_set[SRC_T2]     = tmr_pulse_i[2];
      src_set[SRC_A_FALL] = pin_fall[0];
      src_set[SRC_A_RISE] = pin_rise[0];
      src_set[SRC_B_FALL] = pin_fall[1] | pin_rise[1];
   end

   // ---------------- priority selection ----------------
   assign pend = req_q & mask_q;

   irq_prio_sel #(
      .N     (NUM_SRC),
      .IDX_W (IDX_W)
   ) u_sel (
      .req_i    (pend),
      .any_o    (sel_any),
      .idx_o    (sel_idx),
      .onehot_o (sel_oh)
   );

   assign irq_o  = mstr_q & sel_any;
   assign ack_go = ack_i & irq_o;
   assign vec_o  = sel_any ? VEC_W'(VEC_BASE + VEC_STEP * int'(sel_idx)) : '0;

   // ---------------- register port decode ----------------
   assign wr_enable  = reg_we_i && (reg_sel_e'(reg_addr_i) == RS_ENABLE);
   assign wr_pending = reg_we_i && (reg_sel_e'(reg_addr_i) == RS_PENDING);
   assign wr_filter  = reg_we_i && (reg_sel_e'(reg_addr_i) == RS_FILTER);
   assign unused_wbits = reg_wdata_i[6];

   // ---------------- pending bits ----------------
   assign clr_ack = ack_go ? sel_oh : '0;
   assign clr_sw  = wr_pending ? ~reg_wdata_i[NUM_SRC-1:0] : '0;
   assign req_d   = (req_q & ~(clr_ack | clr_sw)) | src_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= '0;
      else        req_q <= req_d;
   end

   // ---------------- enables ----------------
   always_comb begin
      mstr_d = mstr_q;
      if (wr_enable)             mstr_d = reg_wdata_i[REG_W-1];
      if (mst_set_i || ret_i)    mstr_d = 1'b1;
      if (mst_clr_i || ack_go)   mstr_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         mstr_q <= 1'b0;
      end else begin
         mstr_q <= mstr_d;
         if (wr_enable) mask_q <= reg_wdata_i[NUM_SRC-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hold_q <= HOLD_W'(HOLD_RST);
      else if (wr_filter) hold_q <= reg_wdata_i[HOLD_W-1:0];
   end

   // ---------------- read mux ----------------
   always_comb begin
      reg_rdata_o = '0;
      unique case (reg_sel_e'(reg_addr_i))
         RS_ENABLE:  begin
            reg_rdata_o[NUM_SRC-1:0] = mask_q;
            reg_rdata_o[REG_W-1]     = mstr_q;
         end
         RS_PENDING: reg_rdata_o[NUM_SRC-1:0] = req_q;
         RS_FILTER:  reg_rdata_o[HOLD_W-1:0]  = hold_q;
         RS_RESV:    reg_rdata_o = '0;
         default:    reg_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
   parameter int N        = 6,
   parameter int VEC_W    = 8,
   parameter int VEC_BASE = 2,
   parameter int VEC_STEP = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       tmr_pulse_i,
   input logic             mst_set_i,
   input logic             mst_clr_i,
   input logic             ack_i,
   input logic             ret_i,
   input logic             irq_o,
   input logic [VEC_W-1:0] vec_o,
   input logic [1:0]       reg_addr_i,
   input logic [7:0]       reg_rdata_o,
   input logic             mstr_q,
   input logic [N-1:0]     req_q
);
   localparam int VEC_TOP = VEC_BASE + VEC_STEP * (N - 1);

   // R2: a timer pulse leaves its pending bit set on the next edge
   a_r2_timer0_sets: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_pulse_i[0] |=> req_q[0]);
   a_r2_timer2_sets: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_pulse_i[2] |=> req_q[N-1]);

   // R6: while the line is up the vector lies on an even slot in range
   a_r6_vec_slot: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (vec_o[0] == 1'b0 && int'(vec_o) >= VEC_BASE && int'(vec_o) <= VEC_TOP));

   // R7: an accepted acknowledge drops the line on the next edge
   a_r7_ack_closes: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && irq_o && !mst_set_i && !ret_i) |=> !irq_o);

   // R8: a clear strobe always wins
   a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      mst_clr_i |=> !mstr_q);
   a_r8_set_opens: assert property (@(posedge clk) disable iff (!rst_n)
      ((mst_set_i || ret_i) && !mst_clr_i && !(ack_i && irq_o)) |=> mstr_q);

   // R10: reserved request codes read as zero
   a_r10_resv_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr_i == 2'd3) |-> (reg_rdata_o == 8'h00));
endmodule

bind prio_irq_ctrl irq_ctrl_chk #(
   .N        (irq_pkg::NUM_SRC),
   .VEC_W    (VEC_W),
   .VEC_BASE (VEC_BASE),
   .VEC_STEP (VEC_STEP)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tmr_pulse_i (tmr_pulse_i),
   .mst_set_i   (mst_set_i),
   .mst_clr_i   (mst_clr_i),
   .ack_i       (ack_i),
   .ret_i       (ret_i),
   .irq_o       (irq_o),
   .vec_o       (vec_o),
   .reg_addr_i  (reg_addr_i),
   .reg_rdata_o (reg_rdata_o),
   .mstr_q      (mstr_q),
   .req_q       (req_q)
);

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] tmr_pulse_i = '0;
   logic       ext_a_i = 1'b1;
   logic       ext_b_i = 1'b1;
   logic       reg_we_i = 1'b0;
   logic [1:0] reg_addr_i = '0;
   logic [7:0] reg_wdata_i = '0;
   logic [7:0] reg_rdata_o;
   logic       mst_set_i = 1'b0;
   logic       mst_clr_i = 1'b0;
   logic       ack_i = 1'b0;
   logic       ret_i = 1'b0;
   logic       irq_o;
   logic [7:0] vec_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #(CLK_P / 2) clk = ~clk;

   prio_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .tmr_pulse_i(tmr_pulse_i),
      .ext_a_i(ext_a_i), .ext_b_i(ext_b_i),
      .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
      .reg_rdata_o(reg_rdata_o), .mst_set_i(mst_set_i), .mst_clr_i(mst_clr_i),
      .ack_i(ack_i), .ret_i(ret_i), .irq_o(irq_o), .vec_o(vec_o)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(input int n = 1);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
      cyc();
      reg_we_i = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      reg_addr_i = a;
      #1;
      d = reg_rdata_o;
   endtask

   function automatic int low_bit(input int m);
      for (int i = 0; i < 6; i++) if (m[i]) return i;
      return -1;
   endfunction

   // raise all six requests with the filter at 0
   task automatic load_all();
      tmr_pulse_i = 3'b111; cyc(); tmr_pulse_i = '0;
      ext_a_i = 1'b0; ext_b_i = 1'b0; cyc(5);
      ext_a_i = 1'b1; ext_b_i = 1'b1; cyc(5);
   endtask

   initial begin
      #(CLK_P * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      cyc(2);
      rst_n = 1'b1;
      cyc();

      // R1 reset state
      rd(2'd0, d); chk(d == 8'h00, "R1 enable reg", d, 0);
      rd(2'd1, d); chk(d == 8'h00, "R1 pending reg", d, 0);
      rd(2'd2, d); chk(d == 8'h02, "R1 filter reg", d, 2);
      chk(irq_o == 1'b0, "R1 irq", irq_o, 0);
      chk(vec_o == 8'h00, "R1 vec", vec_o, 0);

      // R2 timer pulses, one at a time
      for (int t = 0; t < 3; t++) begin
         int exp_bit;
         exp_bit = (t == 0) ? 0 : (t == 1) ? 2 : 5;
         tmr_pulse_i = 3'(1 << t); cyc(); tmr_pulse_i = '0;
         rd(2'd1, d); chk(d == 8'(1 << exp_bit), "R2 timer pending", d, 1 << exp_bit);
         wr(2'd1, 8'h00);
      end

      // R4 latency: pending appears on the third edge after the change
      ext_a_i = 1'b0;
      cyc(2); rd(2'd1, d); chk(d == 8'h00, "R4 not yet after two edges", d, 0);
      cyc(1); rd(2'd1, d); chk(d == 8'h02, "R4 set after three edges", d, 2);
      ext_a_i = 1'b1; cyc(8); wr(2'd1, 8'h00);

      // R4 filter sweep: pin A low for n clocks under filter length h
      for (int h = 0; h <= 4; h++) begin
         wr(2'd2, 8'(h));
         for (int n = 1; n <= 6; n++) begin
            int exp;
            cyc(8);
            ext_a_i = 1'b0; cyc(n);
            ext_a_i = 1'b1; cyc(8);
            exp = 2 | ((n >= h) ? 16 : 0);
            rd(2'd1, d); chk(d == 8'(exp), "R4 filter sweep", d, exp);
            wr(2'd1, 8'h00);
         end
      end
      wr(2'd0, 8'h00);
      wr(2'd2, 8'h00);

      // R3 pin B: falling edge only
      ext_b_i = 1'b0; cyc(6); ext_b_i = 1'b1; cyc(6);
      rd(2'd1, d); chk(d == 8'h08, "R3 pin B fall only", d, 8);
      wr(2'd1, 8'h00);
      ext_b_i = 1'b0; cyc(6); wr(2'd1, 8'h00);
      ext_b_i = 1'b1; cyc(6);
      rd(2'd1, d); chk(d == 8'h00, "R3 pin B rise ignored", d, 0);

      // R3 all sources together
      load_all();
      rd(2'd1, d); chk(d == 8'h3F, "R3 all six pending", d, 8'h3F);

      // R5 R6 mask sweep with master on and off
      for (int m = 0; m < 64; m++) begin
         int ev;
         ev = (m == 0) ? 0 : 2 + 2 * low_bit(m);
         wr(2'd0, 8'h80 | 8'(m));
         chk(irq_o == (m != 0), "R5 irq with master on", irq_o, m != 0);
         chk(vec_o == 8'(ev), "R6 vector", vec_o, ev);
         wr(2'd0, 8'(m));
         chk(irq_o == 1'b0, "R5 irq with master off", irq_o, 0);
         chk(vec_o == 8'(ev), "R6 vector master off", vec_o, ev);
      end

      // R7 acknowledge walk through all six in priority order
      wr(2'd0, 8'h3F);
      mst_set_i = 1'b1; cyc(); mst_set_i = 1'b0;
      rd(2'd0, d); chk(d == 8'hBF, "R8 set strobe", d, 8'hBF);
      for (int k = 0; k < 6; k++) begin
         int ep;
         chk(irq_o == 1'b1, "R7 irq before ack", irq_o, 1);
         chk(vec_o == 8'(2 + 2 * k), "R7 vector order", vec_o, 2 + 2 * k);
         ack_i = 1'b1; cyc(); ack_i = 1'b0;
         ep = 8'h3F & ~((1 << (k + 1)) - 1);
         rd(2'd1, d); chk(d == 8'(ep), "R7 ack clears selected", d, ep);
         rd(2'd0, d); chk(d[7] == 1'b0, "R7 ack closes master", d[7], 0);
         chk(irq_o == 1'b0, "R7 irq after ack", irq_o, 0);
         ret_i = 1'b1; cyc(); ret_i = 1'b0;
         rd(2'd0, d); chk(d[7] == 1'b1, "R8 return reopens", d[7], 1);
      end
      chk(vec_o == 8'h00, "R6 none pending", vec_o, 0);
      ack_i = 1'b1; cyc(); ack_i = 1'b0;
      rd(2'd0, d); chk(d == 8'hBF, "R7 idle ack ignored", d, 8'hBF);

      // R8 collisions
      mst_set_i = 1'b1; mst_clr_i = 1'b1; cyc(); mst_set_i = 1'b0; mst_clr_i = 1'b0;
      rd(2'd0, d); chk(d[7] == 1'b0, "R8 clear beats set", d[7], 0);
      reg_we_i = 1'b1; reg_addr_i = 2'd0; reg_wdata_i = 8'h3F; mst_set_i = 1'b1;
      cyc(); reg_we_i = 1'b0; mst_set_i = 1'b0;
      rd(2'd0, d); chk(d == 8'hBF, "R8 strobe beats write", d, 8'hBF);
      mst_clr_i = 1'b1; cyc(); mst_clr_i = 1'b0;
      rd(2'd0, d); chk(d == 8'h3F, "R8 clear strobe", d, 8'h3F);

      // R9 software clear and collision
      tmr_pulse_i = 3'b011; cyc(); tmr_pulse_i = '0;
      wr(2'd1, 8'hFE);
      rd(2'd1, d); chk(d == 8'h04, "R9 write zero clears", d, 4);
      wr(2'd1, 8'h3F);
      rd(2'd1, d); chk(d == 8'h04, "R9 write one no set", d, 4);
      reg_we_i = 1'b1; reg_addr_i = 2'd1; reg_wdata_i = 8'h00; tmr_pulse_i = 3'b001;
      cyc(); reg_we_i = 1'b0; tmr_pulse_i = '0;
      rd(2'd1, d); chk(d == 8'h01, "R9 set wins over clear", d, 1);

      // R10 register layout
      wr(2'd0, 8'hFF);
      rd(2'd0, d); chk(d == 8'hBF, "R10 enable bit6 zero", d, 8'hBF);
      tmr_pulse_i = 3'b111; cyc(); tmr_pulse_i = '0;
      rd(2'd1, d); chk(d[7:6] == 2'b00, "R10 pending high bits", d, 0);
      wr(2'd3, 8'hFF);
      rd(2'd3, d); chk(d == 8'h00, "R10 reserved codes", d, 0);
      wr(2'd2, 8'hFF);
      rd(2'd2, d); chk(d == 8'h0F, "R10 filter width", d, 8'h0F);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule